// File: doc/BRIEF.md
# Receive Ring Admission Gate

This block sits between an incoming frame queue and a host receive descriptor ring. For every frame offered, it works out the length the frame will occupy once padded and given its checksum trailer. It drops over-length frames unless receive control allows them. It then checks whether the ring currently holds enough free descriptors for the frame, and reports an accept or drop verdict one cycle after the frame strobe.

The block owns the ring head pointer, which advances by one on each consumed descriptor and returns to zero at the end of the ring. It also owns the tail pointer, which software writes through a simple register port. A tail write that leaves at least one free descriptor, and any write to receive control, produces a one-cycle request asking the upstream queue to retry delivery of frames it is holding. If the head comes back to the value it had when a frame was admitted while that frame is still being stored, the block raises an overrun flag.

Top module: `rxring_admit`

## Requirements
- R1: After reset, head and tail are 0, and `acc_valid`, `flush_req`, `bufs_avail` and `overrun` are all 0.
- R2: A frame length below 60 is treated as 60 for every later check and for the reported length.
- R3: The reported length `acc_len` is the padded length plus 4. It is the padded length plus 0 when `ctl_crc_strip` is 1.
- R4: A frame whose padded length exceeds 1522 is dropped unless `ctl_long_ok` or `ctl_bad_ok` is 1. The comparison uses the length without the trailer.
- R5: A frame whose reported length is at most `buf_bytes` is accepted exactly when head differs from tail, provided it was not dropped under R4.
- R6: For a longer frame, the free count depends on how head compares with tail:
  - when head is below tail, it is tail minus head;
  - when head is above tail, it is `ring_bytes`/16 plus tail minus head;
  - when head equals tail, it is 0.
  The frame is accepted when the free count times `buf_bytes` is at least the reported length.
- R7: `acc_valid` is high for exactly one cycle, the cycle after `frm_valid`. `acc_ok` and `acc_len` hold the verdict for that frame.
- R8: Each `desc_take` cycle sets head to head+1, or to 0 when (head+1)×16 ≥ `ring_bytes`. Without `desc_take`, head holds.
- R9: A tail write stores bits [15:0] of `tail_wdata`. The next cycle, `flush_req` is 1 if the new tail differs from the head at the time of the write.
- R10: A `ctl_wr` cycle makes `flush_req` 1 in the next cycle. Outside R9 and R10, `flush_req` is 0.
- R11: `bufs_avail` is 1 exactly when head differs from tail.
- R12: `overrun` becomes 1 the cycle after a `desc_take` that brings head back to its value at the last accepted frame. It is cleared by the next `frm_valid`. A dropped frame disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe offering a frame |
| frm_len | input | 16 | Frame length in bytes without trailer |
| ctl_long_ok | input | 1 | Receive control: allow long frames |
| ctl_bad_ok | input | 1 | Receive control: keep bad frames (also bypasses the length drop) |
| ctl_crc_strip | input | 1 | Receive control: no trailer bytes counted |
| ctl_wr | input | 1 | Strobe marking a write to receive control |
| ring_bytes | input | 20 | Ring length register in bytes |
| buf_bytes | input | 16 | Size of one receive buffer in bytes |
| tail_wr | input | 1 | Tail register write strobe |
| tail_wdata | input | 32 | Tail register write data |
| desc_take | input | 1 | One descriptor consumed this cycle |
| acc_valid | output | 1 | Verdict valid |
| acc_ok | output | 1 | Verdict: 1 accept, 0 drop |
| acc_len | output | 17 | Padded length plus trailer of the judged frame |
| bufs_avail | output | 1 | At least one free descriptor |
| flush_req | output | 1 | One-cycle retry request to the upstream queue |
| head | output | 16 | Ring head pointer |
| tail | output | 16 | Ring tail pointer |
| overrun | output | 1 | Head wrapped onto its start during the current frame |

## Verification
The bound checker watches, on every cycle, the parts of the behaviour that can be seen as cause and effect over a single cycle:
- the verdict timing;
- the flush causes;
- the tail write width;
- head stepping and holding;
- drops forced by an empty ring or an over-length frame;
- overrun clearing.

Only the bench scenarios can show the rest. These are the arithmetic of the three free-count paths at the exact thresholds of one descriptor more or one less than needed, the padding and trailer lengths, the wrap point set by `ring_bytes`, and a full lap of the ring that raises overrun. The bench's behavioural model covers all of this, both in directed cases and under random traffic.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
   typedef struct packed {
      logic long_ok;
      logic bad_ok;
      logic crc_strip;
   } rx_ctl_t;
endpackage

// File: rtl/rxring_len_gate.sv
module rxring_len_gate
   import rxring_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int MIN_FRAME = 60,
   parameter int MAX_PLAIN = 1522,
   parameter int FCS_BYTES = 4
) (
   input  logic [LEN_W-1:0] raw_len,
   input  rx_ctl_t          ctl,
   output logic [LEN_W:0]   tot_len,
   output logic             too_long
);
   logic [LEN_W-1:0] pad_len;

   if (MAX_PLAIN < MIN_FRAME) begin : g_bad_limits
      $error("rxring_len_gate: MAX_PLAIN below MIN_FRAME");
   end
   if (MAX_PLAIN >= (1 << LEN_W)) begin : g_bad_width
      $error("rxring_len_gate: MAX_PLAIN does not fit LEN_W");
   end

   always_comb begin
      pad_len  = (raw_len < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : raw_len;
      too_long = (pad_len > LEN_W'(MAX_PLAIN)) && !ctl.long_ok && !ctl.bad_ok;
   end

   if (FCS_BYTES == 0) begin : g_no_trailer
      assign tot_len = {1'b0, pad_len};
   end else begin : g_trailer
      assign tot_len = {1'b0, pad_len} +
                       (ctl.crc_strip ? (LEN_W+1)'(0) : (LEN_W+1)'(FCS_BYTES));
   end
endmodule

// File: rtl/rxring_free_calc.sv
module rxring_free_calc #(
   parameter int PTR_W      = 16,
   parameter int LEN_W      = 16,
   parameter int RLEN_W     = 20,
   parameter int DESC_BYTES = 16
) (
   input  logic [PTR_W-1:0]  head,
   input  logic [PTR_W-1:0]  tail,
   input  logic [RLEN_W-1:0] ring_bytes,
   input  logic [LEN_W-1:0]  buf_bytes,
   input  logic [LEN_W:0]    tot_len,
   output logic              room
);
   localparam int DESC_SH = $clog2(DESC_BYTES);
   localparam int CW      = ((RLEN_W > PTR_W) ? RLEN_W : PTR_W) + 1;
   localparam int PW      = CW + LEN_W + 1;

   logic [CW-1:0] slots, free_cnt, h_w, t_w;
   logic [PW-1:0] cap;
   logic          single;

   if ((1 << DESC_SH) == DESC_BYTES) begin : g_shift
      assign slots = CW'(ring_bytes >> DESC_SH);
   end else begin : g_divide
      assign slots = CW'(ring_bytes / RLEN_W'(DESC_BYTES));
   end

   always_comb begin
      h_w = CW'(head);
      t_w = CW'(tail);
      if (h_w < t_w)      free_cnt = t_w - h_w;
      else if (h_w > t_w) free_cnt = slots + t_w - h_w;
      else                free_cnt = '0;
      cap    = PW'(free_cnt) * PW'(buf_bytes);
      single = tot_len <= {1'b0, buf_bytes};
      room   = single ? (head != tail) : (cap >= PW'(tot_len));
   end
endmodule

// File: rtl/rxring_head_trk.sv
module rxring_head_trk #(
   parameter int PTR_W      = 16,
   parameter int RLEN_W     = 20,
   parameter int DESC_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [RLEN_W-1:0] ring_bytes,
   input  logic              frm_begin,
   input  logic              frm_abort,
   output logic [PTR_W-1:0]  head,
   output logic              overrun
);
   localparam int DESC_SH = $clog2(DESC_BYTES);
   localparam int SW      = PTR_W + 1 + DESC_SH + 1;
   localparam int CW      = (SW > RLEN_W) ? SW : RLEN_W;

   logic [PTR_W:0]   inc;
   logic [CW-1:0]    inc_bytes;
   logic [PTR_W-1:0] head_nxt, start_q;
   logic             live_q;

   always_comb begin
      inc       = {1'b0, head} + 1'b1;
      inc_bytes = CW'(inc) * CW'(DESC_BYTES);
      head_nxt  = (inc_bytes >= CW'(ring_bytes)) ? '0 : inc[PTR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head    <= '0;
         start_q <= '0;
         live_q  <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (take) head <= head_nxt;
         if (frm_begin) begin
            start_q <= head;
            live_q  <= 1'b1;
            overrun <= 1'b0;
         end else if (frm_abort) begin
            live_q  <= 1'b0;
            overrun <= 1'b0;
         end else if (take && live_q && (head_nxt == start_q)) begin
            overrun <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rxring_admit.sv
module rxring_admit
   import rxring_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int PTR_W      = 16,
   parameter int RLEN_W     = 20,
   parameter int DATA_W     = 32,
   parameter int DESC_BYTES = 16,
   parameter int MIN_FRAME  = 60,
   parameter int MAX_PLAIN  = 1522,
   parameter int FCS_BYTES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   input  logic [LEN_W-1:0]  frm_len,
   input  logic              ctl_long_ok,
   input  logic              ctl_bad_ok,
   input  logic              ctl_crc_strip,
   input  logic              ctl_wr,
   input  logic [RLEN_W-1:0] ring_bytes,
   input  logic [LEN_W-1:0]  buf_bytes,
   input  logic              tail_wr,
   input  logic [DATA_W-1:0] tail_wdata,
   input  logic              desc_take,
   output logic              acc_valid,
   output logic              acc_ok,
   output logic [LEN_W:0]    acc_len,
   output logic              bufs_avail,
   output logic              flush_req,
   output logic [PTR_W-1:0]  head,
   output logic [PTR_W-1:0]  tail,
   output logic              overrun
);
   if (DATA_W < PTR_W) begin : g_bad_data
      $error("rxring_admit: DATA_W narrower than PTR_W");
   end
   if (DESC_BYTES < 1) begin : g_bad_desc
      $error("rxring_admit: DESC_BYTES must be positive");
   end

   rx_ctl_t          ctl;
   logic [LEN_W:0]   tot_len;
   logic             too_long, room, ok_now;
   logic [PTR_W-1:0] tail_new;

   always_comb begin
      ctl      = '{long_ok: ctl_long_ok, bad_ok: ctl_bad_ok, crc_strip: ctl_crc_strip};
      ok_now   = room && !too_long;
      tail_new = tail_wdata[PTR_W-1:0];
   end

   rxring_len_gate #(
      .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .MAX_PLAIN(MAX_PLAIN), .FCS_BYTES(FCS_BYTES)
   ) u_len (
      .raw_len(frm_len), .ctl(ctl), .tot_len(tot_len), .too_long(too_long)
   );

   rxring_free_calc #(
      .PTR_W(PTR_W), .LEN_W(LEN_W), .RLEN_W(RLEN_W), .DESC_BYTES(DESC_BYTES)
   ) u_free (
      .head(head), .tail(tail), .ring_bytes(ring_bytes), .buf_bytes(buf_bytes),
      .tot_len(tot_len), .room(room)
   );

   rxring_head_trk #(
      .PTR_W(PTR_W), .RLEN_W(RLEN_W), .DESC_BYTES(DESC_BYTES)
   ) u_head (
      .clk(clk), .rst_n(rst_n), .take(desc_take), .ring_bytes(ring_bytes),
      .frm_begin(frm_valid && ok_now), .frm_abort(frm_valid && !ok_now),
      .head(head), .overrun(overrun)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_valid <= 1'b0;
         acc_ok    <= 1'b0;
         acc_len   <= '0;
         tail      <= '0;
         flush_req <= 1'b0;
      end else begin
         acc_valid <= frm_valid;
         if (frm_valid) begin
            acc_ok  <= ok_now;
            acc_len <= tot_len;
         end
         if (tail_wr) tail <= tail_new;
         flush_req <= ctl_wr || (tail_wr && (tail_new != head));
      end
   end

   assign bufs_avail = (head != tail);
endmodule

// File: rtl/rxring_admit_chk.sv
module rxring_admit_chk #(
   parameter int LEN_W     = 16,
   parameter int PTR_W     = 16,
   parameter int DATA_W    = 32,
   parameter int MAX_PLAIN = 1522
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_valid,
   input logic [LEN_W-1:0]  frm_len,
   input logic              ctl_long_ok,
   input logic              ctl_bad_ok,
   input logic              ctl_wr,
   input logic              tail_wr,
   input logic [DATA_W-1:0] tail_wdata,
   input logic              desc_take,
   input logic              acc_valid,
   input logic              acc_ok,
   input logic              flush_req,
   input logic [PTR_W-1:0]  head,
   input logic [PTR_W-1:0]  tail,
   input logic              overrun
);
   a_r7_verdict_follows: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> acc_valid);
   a_r7_no_stray_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_valid |=> !acc_valid);
   a_r10_ctl_flush: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> flush_req);
   a_r10_flush_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr && !tail_wr |=> !flush_req);
   a_r9_tail_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      tail_wr |=> (tail == $past(tail_wdata[PTR_W-1:0])));
   a_r8_head_steps: assert property (@(posedge clk) disable iff (!rst_n)
      desc_take |=> (head == '0 || head == $past(head) + 1'b1));
   a_r8_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !desc_take |=> $stable(head));
   a_r5_empty_ring_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && head == tail) |=> !acc_ok);
   a_r4_long_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_len > LEN_W'(MAX_PLAIN) && !ctl_long_ok && !ctl_bad_ok) |=> !acc_ok);
   a_r12_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> !overrun);
endmodule

bind rxring_admit rxring_admit_chk #(
   .LEN_W(LEN_W), .PTR_W(PTR_W), .DATA_W(DATA_W), .MAX_PLAIN(MAX_PLAIN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
   .ctl_long_ok(ctl_long_ok), .ctl_bad_ok(ctl_bad_ok), .ctl_wr(ctl_wr),
   .tail_wr(tail_wr), .tail_wdata(tail_wdata), .desc_take(desc_take),
   .acc_valid(acc_valid), .acc_ok(acc_ok), .flush_req(flush_req),
   .head(head), .tail(tail), .overrun(overrun)
);

// File: tb/rxring_admit_tb.sv
module rxring_admit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic [15:0] frm_len = '0;
   logic        ctl_long_ok = 1'b0, ctl_bad_ok = 1'b0, ctl_crc_strip = 1'b0, ctl_wr = 1'b0;
   logic [19:0] ring_bytes = 20'd128;
   logic [15:0] buf_bytes = 16'd256;
   logic        tail_wr = 1'b0;
   logic [31:0] tail_wdata = '0;
   logic        desc_take = 1'b0;
   logic        acc_valid, acc_ok, bufs_avail, flush_req, overrun;
   logic [16:0] acc_len;
   logic [15:0] head, tail;

   int    tests = 0, fails = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   rxring_admit u_dut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
      .ctl_long_ok(ctl_long_ok), .ctl_bad_ok(ctl_bad_ok), .ctl_crc_strip(ctl_crc_strip),
      .ctl_wr(ctl_wr), .ring_bytes(ring_bytes), .buf_bytes(buf_bytes),
      .tail_wr(tail_wr), .tail_wdata(tail_wdata), .desc_take(desc_take),
      .acc_valid(acc_valid), .acc_ok(acc_ok), .acc_len(acc_len),
      .bufs_avail(bufs_avail), .flush_req(flush_req), .head(head), .tail(tail),
      .overrun(overrun)
   );

   // behavioural reference model
   int    m_head = 0, m_tail = 0, m_len = 0, m_start = 0;
   bit    m_av = 0, m_ok = 0, m_flush = 0, m_live = 0, m_ovr = 0;
   string m_ftag = "R10";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_head = 0; m_tail = 0; m_av = 0; m_ok = 0; m_len = 0;
         m_flush = 0; m_live = 0; m_ovr = 0; m_start = 0;
      end else begin
         int  plen, tot, slots, freec, need, nh, old_head;
         bit  ok;
         old_head = m_head;
         plen  = (frm_len < 60) ? 60 : int'(frm_len);
         tot   = plen + (ctl_crc_strip ? 0 : 4);
         slots = int'(ring_bytes) / 16;
         if (m_head < m_tail)      freec = m_tail - m_head;
         else if (m_head > m_tail) freec = slots + m_tail - m_head;
         else                      freec = 0;
         need = (tot + int'(buf_bytes) - 1) / int'(buf_bytes);
         if (tot <= int'(buf_bytes)) ok = (m_head != m_tail);
         else                         ok = (freec >= need);
         if (plen > 1522 && !ctl_long_ok && !ctl_bad_ok) ok = 0;
         nh = m_head + 1;
         if (nh * 16 >= int'(ring_bytes)) nh = 0;
         m_av = frm_valid;
         if (frm_valid) begin m_ok = ok; m_len = tot; end
         m_flush = ctl_wr || (tail_wr && int'(tail_wdata[15:0]) != old_head);
         m_ftag  = ctl_wr ? "R10" : "R9";
         if (frm_valid) begin
            if (ok) begin m_start = old_head; m_live = 1; end
            else m_live = 0;
            m_ovr = 0;
         end else if (desc_take && m_live && nh == m_start) begin
            m_ovr = 1;
         end
         if (tail_wr) m_tail = int'(tail_wdata[15:0]);
         if (desc_take) m_head = nh;
      end
   end

   task automatic chk(string req, string what, longint act, longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R7", "acc_valid", acc_valid, m_av);
         if (m_av) begin
            chk(cur_req, "acc_ok", acc_ok, m_ok);
            chk((cur_req == "R2") ? "R2" : "R3", "acc_len", acc_len, m_len);
         end
         chk(m_ftag, "flush_req", flush_req, m_flush);
         chk("R8", "head", head, m_head);
         chk("R9", "tail", tail, m_tail);
         chk("R11", "bufs_avail", bufs_avail, (m_head != m_tail));
         chk("R12", "overrun", overrun, m_ovr);
      end
   end

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic frame(int len, string req);
      cur_req = req; frm_len = 16'(len); frm_valid = 1'b1;
      tick(); frm_valid = 1'b0; tick();
   endtask

   task automatic wr_tail(logic [31:0] v);
      tail_wdata = v; tail_wr = 1'b1; tick(); tail_wr = 1'b0; tick();
   endtask

   task automatic take(int n);
      desc_take = 1'b1; repeat (n) tick(); desc_take = 1'b0; tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1", "head", head, 0);
      chk("R1", "tail", tail, 0);
      chk("R1", "acc_valid", acc_valid, 0);
      chk("R1", "flush_req", flush_req, 0);
      chk("R1", "bufs_avail", bufs_avail, 0);
      chk("R1", "overrun", overrun, 0);
      tick();
      // R9: low 16 bits stored, flush only when tail differs from head
      wr_tail(32'h0003_0005);
      wr_tail(32'hABCD_0000);
      wr_tail(32'h0000_0005);
      // R10: receive-control write
      ctl_wr = 1'b1; tick(); ctl_wr = 1'b0; tick();
      // R2 and R3: padding and trailer
      frame(10, "R2");
      ctl_crc_strip = 1'b1; frame(10, "R2"); frame(200, "R3");
      ctl_crc_strip = 1'b0; frame(200, "R3");
      // R4: long frames with single large buffer
      buf_bytes = 16'd2048;
      frame(1600, "R4"); frame(1522, "R4"); frame(1523, "R4");
      ctl_long_ok = 1'b1; frame(1600, "R4"); ctl_long_ok = 1'b0;
      ctl_bad_ok  = 1'b1; frame(1600, "R4"); ctl_bad_ok  = 1'b0;
      // R6: multi-buffer free counts
      buf_bytes = 16'd256;
      frame(1000, "R6"); frame(1300, "R6"); frame(1276, "R6"); frame(1277, "R6");
      take(6);
      frame(1700, "R6"); frame(1800, "R6");
      wr_tail(32'h0000_0006);
      frame(300, "R6");
      frame(100, "R5");
      // R8: wrap at ring end
      take(2);
      // R12: full lap during one frame
      frame(100, "R12");
      take(8);
      frame(100, "R12");
      // random traffic
      for (int i = 0; i < 600; i++) begin
         cur_req       = "R6";
         frm_valid     = ($urandom % 4) == 0;
         frm_len       = 16'($urandom % 2100);
         ctl_long_ok   = ($urandom % 5) == 0;
         ctl_bad_ok    = ($urandom % 7) == 0;
         ctl_crc_strip = ($urandom % 2) == 0;
         ctl_wr        = ($urandom % 9) == 0;
         tail_wr       = ($urandom % 6) == 0;
         tail_wdata    = {16'($urandom), 16'($urandom % 8)};
         desc_take     = ($urandom % 3) == 0;
         case ($urandom % 3)
            0: buf_bytes = 16'd64;
            1: buf_bytes = 16'd256;
            default: buf_bytes = 16'd2048;
         endcase
         tick();
      end
      frm_valid = 1'b0; ctl_wr = 1'b0; tail_wr = 1'b0; desc_take = 1'b0;
      repeat (3) tick();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule